// File: doc/BRIEF.md
# Montgomery Ladder Micro-Operation Sequencer

This block is the control engine for a Curve25519 x-only scalar multiplication. It walks a 256-bit scalar from the top bit down. For each bit it issues a fixed program of micro-operations to an external modular arithmetic unit. The operations are move, add, subtract and multiply. Each one names an opcode, a source bank with two operand slots, a destination bank with two slots, and a modulus select.

Every operation reads one of two ping-pong operand banks and writes the other. The conditional swap of the two ladder points is done lazily. A remembered flag is compared with the current scalar bit, and that comparison picks the order of the two copy moves that start each step.

After the last step, the block requests the modular inverse of the projective Z, multiplies by X, adds zero under the single modulus to complete the reduction, and stores the result. The arithmetic unit, the inverse routine and the operand memories sit outside, behind a hold-until-done handshake. The constants zero, one and a24 (0x1DB42) are expected in both banks.

Top module: `mont_ladder_seq`

## Requirements
- R1: After reset, busy_o, done_o and op_valid_o are low. A start_i pulse while idle makes busy_o and op_valid_o high from the next cycle. When the last operation is accepted, busy_o falls and done_o is high for exactly one cycle.
- R2: Encodings. Opcodes: LOAD=0, MOVE=1, ADD=2, SUB=3, MUL=4, INV=5, STORE=6. Bank: 0 is low, 1 is high. Modulus select: 0 is 2P, 1 is P. Slots: ZERO=0, ONE=1, A24=2; R0X,R0Z,R1X,R1Z=3..6; T0X,T0Z,T1X,T1Z=7..10; S0,S1,D0,D1=11..14; QS0,QD0,S0D1,S1D0=15..18; TS,TD,QTD=19..21; T0,TA,T1=22..24; PX=25; INV_IN=26; INV_OUT=27; INV_TMP=28. Arithmetic ops repeat their destination slot in both destination fields. Fields an op does not use are zero, and the modulus select of non-arithmetic ops is 0.
- R3: The operation fields stay stable and op_valid_o stays high until op_done_i is sampled high. The next operation appears in the following cycle. op_done_i is ignored while op_valid_o is low.
- R4: The run opens with three operations, in order: LOAD of the input point into high slot PX; MOVE high (ONE,ZERO) to low (R0X,R0Z); MOVE high (PX,ONE) to low (R1X,R1Z).
- R5: The scalar is sampled from scalar_i on the start cycle. Word w occupies bits [32w+31:32w], and step s (s = 0..255) uses flat bit 255-s. Later changes of scalar_i have no effect on the run.
- R6: The swap flag is 0 at start. Each step begins with two MOVEs from low to high. If flag equals the bit, the order is (R0X,R0Z) to (T0X,T0Z), then (R1X,R1Z) to (T1X,T1Z). Otherwise it is (R1X,R1Z) to (T0X,T0Z), then (R0X,R0Z) to (T1X,T1Z). The flag then takes the bit's value.
- R7: Each step then issues 18 arithmetic ops, all under modulus 2P, in this order. Each op reads the bank shown on the left and writes the bank shown on the right.
  - ADD T0X+T0Z→S0, ADD T1X+T1Z→S1, SUB T0X−T0Z→D0, SUB T1X−T1Z→D1 (high to low).
  - MUL S0·S0→QS0, D0·D0→QD0, S0·D1→S0D1, S1·D0→S1D0 (low to high).
  - ADD S1D0+S0D1→TS, SUB S1D0−S0D1→TD (high to low).
  - MUL TD·TD→QTD (low to high).
  - SUB QS0−QD0→T0 (high to low).
  - MUL T0·A24→TA (low to high).
  - ADD TA+QD0→T1 (high to low).
  - MUL QS0·QD0→R0X (high to low).
  - MUL T0·T1→R0Z (low to high).
  - MUL TS·TS→R1X (low to high).
  - MUL PX·QTD→R1Z (high to low).
- R8: Each step closes with MOVE high (R0Z,R1X) to low (R0Z,R1X).
- R9: After step 255 the run ends with six operations, in order:
  - MOVE high (R0Z,R0Z) to low (INV_IN,INV_IN).
  - INV low (INV_IN,INV_IN) to high (INV_OUT,INV_OUT).
  - MOVE high (INV_OUT,INV_OUT) to low (INV_OUT,INV_OUT).
  - MUL low INV_OUT·R0X to high INV_TMP, modulus 2P.
  - ADD high INV_TMP+ZERO to low INV_OUT, modulus P.
  - STORE from low (INV_OUT,INV_OUT).
- R10: Every run issues exactly 3 + 256·21 + 6 = 5385 operations, whatever the scalar.
- R11: start_i while busy has no effect on the running sequence.
- R12: Every ADD, SUB and MUL names different source and destination banks. Only the final reduction uses modulus P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run when idle |
| scalar_i | input | 256 | Scalar, eight 32-bit words |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at run end |
| op_valid_o | output | 1 | Operation presented |
| op_code_o | output | 3 | Opcode |
| op_src_bank_o | output | 1 | Source bank |
| op_src_a_o | output | 5 | First source slot |
| op_src_b_o | output | 5 | Second source slot |
| op_dst_bank_o | output | 1 | Destination bank |
| op_dst_a_o | output | 5 | First destination slot |
| op_dst_b_o | output | 5 | Second destination slot |
| op_mod_o | output | 1 | Modulus select |
| op_done_i | input | 1 | Arithmetic unit finished the presented operation |

## Verification
The hold and sequencing properties assume that op_done_i is a single-cycle pulse. They also assume that start_i is a single-cycle pulse. The arithmetic stub in the bench samples each operation and waits a fixed latency of zero to two cycles. It then raises op_done_i for exactly one cycle and never holds it across two operations. Stray op_done_i and start_i pulses are driven only at chosen moments, while idle or in the middle of a wait, so that the handshake rules the assertions rely on are never broken by the bench itself.

// File: rtl/ladder_seq_pkg.sv
package ladder_seq_pkg;

  localparam int SLOT_W    = 5;
  localparam int INIT_OPS  = 3;
  localparam int STEP_OPS  = 21;
  localparam int TAIL_OPS  = 6;
  localparam int OPI_W     = $clog2(STEP_OPS);

  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_MOVE  = 3'd1,
    OP_ADD   = 3'd2,
    OP_SUB   = 3'd3,
    OP_MUL   = 3'd4,
    OP_INV   = 3'd5,
    OP_STORE = 3'd6
  } op_code_e;

  typedef enum logic {BANK_LO = 1'b0, BANK_HI = 1'b1} bank_e;
  typedef enum logic {MOD_2P = 1'b0, MOD_1P = 1'b1} mod_e;
  typedef enum logic [1:0] {PH_IDLE, PH_INIT, PH_STEP, PH_TAIL} phase_e;

  localparam slot_t SL_ZERO    = 5'd0;
  localparam slot_t SL_ONE     = 5'd1;
  localparam slot_t SL_A24     = 5'd2;
  localparam slot_t SL_R0X     = 5'd3;
  localparam slot_t SL_R0Z     = 5'd4;
  localparam slot_t SL_R1X     = 5'd5;
  localparam slot_t SL_R1Z     = 5'd6;
  localparam slot_t SL_T0X     = 5'd7;
  localparam slot_t SL_T0Z     = 5'd8;
  localparam slot_t SL_T1X     = 5'd9;
  localparam slot_t SL_T1Z     = 5'd10;
  localparam slot_t SL_S0      = 5'd11;
  localparam slot_t SL_S1      = 5'd12;
  localparam slot_t SL_D0      = 5'd13;
  localparam slot_t SL_D1      = 5'd14;
  localparam slot_t SL_QS0     = 5'd15;
  localparam slot_t SL_QD0     = 5'd16;
  localparam slot_t SL_S0D1    = 5'd17;
  localparam slot_t SL_S1D0    = 5'd18;
  localparam slot_t SL_TS      = 5'd19;
  localparam slot_t SL_TD      = 5'd20;
  localparam slot_t SL_QTD     = 5'd21;
  localparam slot_t SL_T0      = 5'd22;
  localparam slot_t SL_TA      = 5'd23;
  localparam slot_t SL_T1      = 5'd24;
  localparam slot_t SL_PX      = 5'd25;
  localparam slot_t SL_INV_IN  = 5'd26;
  localparam slot_t SL_INV_OUT = 5'd27;
  localparam slot_t SL_INV_TMP = 5'd28;

  typedef struct packed {
    op_code_e code;
    bank_e    src_bank;
    slot_t    src_a;
    slot_t    src_b;
    bank_e    dst_bank;
    slot_t    dst_a;
    slot_t    dst_b;
    mod_e     modsel;
  } uop_t;

  function automatic bank_e other_bank(bank_e b);
    return (b == BANK_LO) ? BANK_HI : BANK_LO;
  endfunction

  function automatic uop_t mk_op(op_code_e c, bank_e sb, slot_t a, slot_t b,
                                 bank_e db, slot_t x, slot_t y, mod_e m);
    uop_t u;
    u.code     = c;
    u.src_bank = sb;
    u.src_a    = a;
    u.src_b    = b;
    u.dst_bank = db;
    u.dst_a    = x;
    u.dst_b    = y;
    u.modsel   = m;
    return u;
  endfunction

  function automatic uop_t mk_calc(op_code_e c, bank_e sb, slot_t a, slot_t b, slot_t d);
    return mk_op(c, sb, a, b, other_bank(sb), d, d, MOD_2P);
  endfunction

  function automatic uop_t mk_move(bank_e sb, slot_t a, slot_t b, slot_t x, slot_t y);
    return mk_op(OP_MOVE, sb, a, b, other_bank(sb), x, y, MOD_2P);
  endfunction

endpackage

// File: rtl/ladder_bit_sel.sv
module ladder_bit_sel #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  localparam int SCALAR_W = WORD_W * NUM_WORDS,
  localparam int IDX_W    = $clog2(SCALAR_W),
  localparam int WB_W     = $clog2(WORD_W)
) (
  input  logic [SCALAR_W-1:0] scalar_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic                bit_o
);

  logic [WORD_W-1:0] words [NUM_WORDS];
  logic [WORD_W-1:0] sel_word;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign words[w] = scalar_i[w*WORD_W +: WORD_W];
  end

  // word index then bit index: independent of the scalar value
  assign sel_word = words[idx_i[IDX_W-1:WB_W]];
  assign bit_o    = sel_word[idx_i[WB_W-1:0]];

endmodule

// File: rtl/ladder_op_rom.sv
module ladder_op_rom
  import ladder_seq_pkg::*;
(
  input  phase_e           phase_i,
  input  logic [OPI_W-1:0] idx_i,
  input  logic             swap_i,
  output uop_t             op_o
);

  uop_t init_op, step_op, tail_op;

  always_comb begin
    init_op = mk_op(OP_LOAD, BANK_LO, SL_ZERO, SL_ZERO, BANK_HI, SL_PX, SL_PX, MOD_2P);
    unique case (idx_i)
      OPI_W'(1): init_op = mk_move(BANK_HI, SL_ONE, SL_ZERO, SL_R0X, SL_R0Z);
      OPI_W'(2): init_op = mk_move(BANK_HI, SL_PX, SL_ONE, SL_R1X, SL_R1Z);
      default: ;
    endcase
  end

  always_comb begin
    step_op = mk_move(BANK_HI, SL_R0Z, SL_R1X, SL_R0Z, SL_R1X);
    unique case (idx_i)
      OPI_W'(0):  step_op = swap_i ? mk_move(BANK_LO, SL_R1X, SL_R1Z, SL_T0X, SL_T0Z)
                                   : mk_move(BANK_LO, SL_R0X, SL_R0Z, SL_T0X, SL_T0Z);
      OPI_W'(1):  step_op = swap_i ? mk_move(BANK_LO, SL_R0X, SL_R0Z, SL_T1X, SL_T1Z)
                                   : mk_move(BANK_LO, SL_R1X, SL_R1Z, SL_T1X, SL_T1Z);
      OPI_W'(2):  step_op = mk_calc(OP_ADD, BANK_HI, SL_T0X,  SL_T0Z,  SL_S0);
      OPI_W'(3):  step_op = mk_calc(OP_ADD, BANK_HI, SL_T1X,  SL_T1Z,  SL_S1);
      OPI_W'(4):  step_op = mk_calc(OP_SUB, BANK_HI, SL_T0X,  SL_T0Z,  SL_D0);
      OPI_W'(5):  step_op = mk_calc(OP_SUB, BANK_HI, SL_T1X,  SL_T1Z,  SL_D1);
      OPI_W'(6):  step_op = mk_calc(OP_MUL, BANK_LO, SL_S0,   SL_S0,   SL_QS0);
      OPI_W'(7):  step_op = mk_calc(OP_MUL, BANK_LO, SL_D0,   SL_D0,   SL_QD0);
      OPI_W'(8):  step_op = mk_calc(OP_MUL, BANK_LO, SL_S0,   SL_D1,   SL_S0D1);
      OPI_W'(9):  step_op = mk_calc(OP_MUL, BANK_LO, SL_S1,   SL_D0,   SL_S1D0);
      OPI_W'(10): step_op = mk_calc(OP_ADD, BANK_HI, SL_S1D0, SL_S0D1, SL_TS);
      OPI_W'(11): step_op = mk_calc(OP_SUB, BANK_HI, SL_S1D0, SL_S0D1, SL_TD);
      OPI_W'(12): step_op = mk_calc(OP_MUL, BANK_LO, SL_TD,   SL_TD,   SL_QTD);
      OPI_W'(13): step_op = mk_calc(OP_SUB, BANK_HI, SL_QS0,  SL_QD0,  SL_T0);
      OPI_W'(14): step_op = mk_calc(OP_MUL, BANK_LO, SL_T0,   SL_A24,  SL_TA);
      OPI_W'(15): step_op = mk_calc(OP_ADD, BANK_HI, SL_TA,   SL_QD0,  SL_T1);
      OPI_W'(16): step_op = mk_calc(OP_MUL, BANK_HI, SL_QS0,  SL_QD0,  SL_R0X);
      OPI_W'(17): step_op = mk_calc(OP_MUL, BANK_LO, SL_T0,   SL_T1,   SL_R0Z);
      OPI_W'(18): step_op = mk_calc(OP_MUL, BANK_LO, SL_TS,   SL_TS,   SL_R1X);
      OPI_W'(19): step_op = mk_calc(OP_MUL, BANK_HI, SL_PX,   SL_QTD,  SL_R1Z);
      default: ;
    endcase
  end

  always_comb begin
    tail_op = mk_move(BANK_HI, SL_R0Z, SL_R0Z, SL_INV_IN, SL_INV_IN);
    unique case (idx_i)
      OPI_W'(1): tail_op = mk_op(OP_INV, BANK_LO, SL_INV_IN, SL_INV_IN,
                                 BANK_HI, SL_INV_OUT, SL_INV_OUT, MOD_2P);
      OPI_W'(2): tail_op = mk_move(BANK_HI, SL_INV_OUT, SL_INV_OUT, SL_INV_OUT, SL_INV_OUT);
      OPI_W'(3): tail_op = mk_calc(OP_MUL, BANK_LO, SL_INV_OUT, SL_R0X, SL_INV_TMP);
      OPI_W'(4): tail_op = mk_op(OP_ADD, BANK_HI, SL_INV_TMP, SL_ZERO,
                                 BANK_LO, SL_INV_OUT, SL_INV_OUT, MOD_1P);
      OPI_W'(5): tail_op = mk_op(OP_STORE, BANK_LO, SL_INV_OUT, SL_INV_OUT,
                                 BANK_LO, SL_ZERO, SL_ZERO, MOD_2P);
      default: ;
    endcase
  end

  always_comb begin
    unique case (phase_i)
      PH_INIT: op_o = init_op;
      PH_STEP: op_o = step_op;
      PH_TAIL: op_o = tail_op;
      default: op_o = mk_op(OP_LOAD, BANK_LO, SL_ZERO, SL_ZERO, BANK_LO, SL_ZERO, SL_ZERO, MOD_2P);
    endcase
  end

endmodule

// File: rtl/ladder_ctrl.sv
module ladder_ctrl
  import ladder_seq_pkg::*;
#(
  parameter int SCALAR_W = 256,
  localparam int BIDX_W  = $clog2(SCALAR_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_done_i,
  input  logic              cur_bit_i,
  output phase_e            phase_o,
  output logic [OPI_W-1:0]  op_idx_o,
  output logic [BIDX_W-1:0] bit_idx_o,
  output logic              swap_o,
  output logic              launch_o,
  output logic              busy_o,
  output logic              done_o
);

  phase_e             phase_q;
  logic [OPI_W-1:0]   op_idx_q;
  logic [BIDX_W-1:0]  bit_idx_q;
  logic               flag_q;
  logic               done_q;
  logic               last_op;
  logic               fire;

  assign launch_o = (phase_q == PH_IDLE) && start_i;
  assign fire     = (phase_q != PH_IDLE) && op_done_i;

  always_comb begin
    unique case (phase_q)
      PH_INIT: last_op = (op_idx_q == OPI_W'(INIT_OPS-1));
      PH_STEP: last_op = (op_idx_q == OPI_W'(STEP_OPS-1));
      PH_TAIL: last_op = (op_idx_q == OPI_W'(TAIL_OPS-1));
      default: last_op = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      op_idx_q  <= '0;
      bit_idx_q <= '0;
      flag_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch_o) begin
        phase_q   <= PH_INIT;
        op_idx_q  <= '0;
        bit_idx_q <= BIDX_W'(SCALAR_W-1);
        flag_q    <= 1'b0;
      end else if (fire) begin
        if (!last_op) begin
          op_idx_q <= op_idx_q + 1'b1;
          // flag follows the bit once both swap moves are accepted
          if (phase_q == PH_STEP && op_idx_q == OPI_W'(1)) flag_q <= cur_bit_i;
        end else begin
          op_idx_q <= '0;
          unique case (phase_q)
            PH_INIT: phase_q <= PH_STEP;
            PH_STEP: begin
              if (bit_idx_q == '0) phase_q <= PH_TAIL;
              else bit_idx_q <= bit_idx_q - 1'b1;
            end
            PH_TAIL: begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign phase_o   = phase_q;
  assign op_idx_o  = op_idx_q;
  assign bit_idx_o = bit_idx_q;
  assign swap_o    = flag_q ^ cur_bit_i;
  assign busy_o    = (phase_q != PH_IDLE);
  assign done_o    = done_q;

  assert_flag_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (!flag_q && op_idx_q == '0 && bit_idx_q == BIDX_W'(SCALAR_W-1)));

  assert_bit_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && phase_q == PH_STEP && last_op && bit_idx_q != '0)
      |=> (bit_idx_q == BIDX_W'($past(bit_idx_q) - 1'b1)));

  assert_start_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !op_done_i)
      |=> ($stable(op_idx_q) && $stable(bit_idx_q) && $stable(phase_q)));

endmodule

// File: rtl/mont_ladder_seq.sv
module mont_ladder_seq
  import ladder_seq_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  localparam int SCALAR_W = WORD_W * NUM_WORDS,
  localparam int BIDX_W   = $clog2(SCALAR_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SCALAR_W-1:0] scalar_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                op_valid_o,
  output logic [2:0]          op_code_o,
  output logic                op_src_bank_o,
  output logic [SLOT_W-1:0]   op_src_a_o,
  output logic [SLOT_W-1:0]   op_src_b_o,
  output logic                op_dst_bank_o,
  output logic [SLOT_W-1:0]   op_dst_a_o,
  output logic [SLOT_W-1:0]   op_dst_b_o,
  output logic                op_mod_o,
  input  logic                op_done_i
);

  logic [SCALAR_W-1:0] scalar_q;
  phase_e              phase;
  logic [OPI_W-1:0]    op_idx;
  logic [BIDX_W-1:0]   bit_idx;
  logic                cur_bit;
  logic                swap;
  logic                launch;
  uop_t                op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scalar_q <= '0;
    else if (launch) scalar_q <= scalar_i;
  end

  ladder_bit_sel #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS)
  ) u_bit_sel (
    .scalar_i (scalar_q),
    .idx_i    (bit_idx),
    .bit_o    (cur_bit)
  );

  ladder_ctrl #(
    .SCALAR_W (SCALAR_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .op_done_i (op_done_i),
    .cur_bit_i (cur_bit),
    .phase_o   (phase),
    .op_idx_o  (op_idx),
    .bit_idx_o (bit_idx),
    .swap_o    (swap),
    .launch_o  (launch),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  ladder_op_rom u_rom (
    .phase_i (phase),
    .idx_i   (op_idx),
    .swap_i  (swap),
    .op_o    (op)
  );

  assign op_valid_o    = busy_o;
  assign op_code_o     = op.code;
  assign op_src_bank_o = op.src_bank;
  assign op_src_a_o    = op.src_a;
  assign op_src_b_o    = op.src_b;
  assign op_dst_bank_o = op.dst_bank;
  assign op_dst_a_o    = op.dst_a;
  assign op_dst_b_o    = op.dst_b;
  assign op_mod_o      = op.modsel;

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && !op_done_i) |=> (op_valid_o && $stable(op)));

  assert_done_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_bank_flip_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && (op.code == OP_ADD || op.code == OP_SUB || op.code == OP_MUL))
      |-> (op.src_bank != op.dst_bank));

  assert_single_mod_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op.modsel == MOD_1P) |-> (op.code == OP_ADD && op.src_b == SL_ZERO));

endmodule

// File: tb/mont_ladder_seq_bench.sv
module mont_ladder_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 190000;
  localparam int STEPS      = 256;
  localparam int TOTAL_OPS  = 3 + STEPS * 21 + 6;

  localparam int C_LOAD = 0, C_MOVE = 1, C_ADD = 2, C_SUB = 3, C_MUL = 4, C_INV = 5, C_STORE = 6;
  localparam int Z0 = 0, ONE = 1, A24 = 2, R0X = 3, R0Z = 4, R1X = 5, R1Z = 6;
  localparam int T0X = 7, T0Z = 8, T1X = 9, T1Z = 10, S0 = 11, S1 = 12, D0 = 13, D1 = 14;
  localparam int QS0 = 15, QD0 = 16, S0D1 = 17, S1D0 = 18, TS = 19, TD = 20, QTD = 21;
  localparam int T0 = 22, TA = 23, T1 = 24, PX = 25, IVI = 26, IVO = 27, IVT = 28;

  localparam int NVEC = 4;
  localparam logic [255:0] VEC_K [NVEC] = '{
    256'h0,
    {256{1'b1}},
    {64{4'hA}},
    256'h5d3c9a710f2e8b44c6a137d9e2501f8c9b037a6ed4c215f88e27b6a94c3107d8
  };
  localparam int VEC_LAT   [NVEC] = '{0, 1, 2, 1};
  localparam int VEC_SMID  [NVEC] = '{0, 0, 1, 0};
  localparam int VEC_KMID  [NVEC] = '{0, 0, 0, 1};

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [255:0] scalar_i = '0;
  logic         op_done_i = 1'b0;
  logic         busy_o, done_o, op_valid_o;
  logic [2:0]   op_code_o;
  logic         op_src_bank_o, op_dst_bank_o, op_mod_o;
  logic [4:0]   op_src_a_o, op_src_b_o, op_dst_a_o, op_dst_b_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic timed_out = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc >= WD_LIMIT) timed_out <= 1'b1;
  end

  mont_ladder_seq u_mont_ladder_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .scalar_i      (scalar_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .op_valid_o    (op_valid_o),
    .op_code_o     (op_code_o),
    .op_src_bank_o (op_src_bank_o),
    .op_src_a_o    (op_src_a_o),
    .op_src_b_o    (op_src_b_o),
    .op_dst_bank_o (op_dst_bank_o),
    .op_dst_a_o    (op_dst_a_o),
    .op_dst_b_o    (op_dst_b_o),
    .op_mod_o      (op_mod_o),
    .op_done_i     (op_done_i)
  );

  function automatic logic [25:0] pk(input int c, input int sb, input int a, input int b,
                                     input int db, input int x, input int y, input int m);
    return {3'(c), 1'(sb), 5'(a), 5'(b), 1'(db), 5'(x), 5'(y), 1'(m)};
  endfunction

  function automatic logic [25:0] dut_op();
    return {op_code_o, op_src_bank_o, op_src_a_o, op_src_b_o,
            op_dst_bank_o, op_dst_a_o, op_dst_b_o, op_mod_o};
  endfunction

  // expected trace built from the requirement text
  function automatic logic [25:0] exp_op(input logic [255:0] k, input int n);
    int s, j;
    logic kb, fl;
    exp_op = '0;
    if (n < 3) begin
      case (n)
        0: exp_op = pk(C_LOAD, 0, 0, 0, 1, PX, PX, 0);
        1: exp_op = pk(C_MOVE, 1, ONE, Z0, 0, R0X, R0Z, 0);
        default: exp_op = pk(C_MOVE, 1, PX, ONE, 0, R1X, R1Z, 0);
      endcase
    end else if (n < 3 + STEPS * 21) begin
      s  = (n - 3) / 21;
      j  = (n - 3) % 21;
      kb = k[255 - s];
      fl = (s == 0) ? 1'b0 : k[256 - s];
      case (j)
        0:  exp_op = (kb == fl) ? pk(C_MOVE, 0, R0X, R0Z, 1, T0X, T0Z, 0)
                                : pk(C_MOVE, 0, R1X, R1Z, 1, T0X, T0Z, 0);
        1:  exp_op = (kb == fl) ? pk(C_MOVE, 0, R1X, R1Z, 1, T1X, T1Z, 0)
                                : pk(C_MOVE, 0, R0X, R0Z, 1, T1X, T1Z, 0);
        2:  exp_op = pk(C_ADD, 1, T0X, T0Z, 0, S0, S0, 0);
        3:  exp_op = pk(C_ADD, 1, T1X, T1Z, 0, S1, S1, 0);
        4:  exp_op = pk(C_SUB, 1, T0X, T0Z, 0, D0, D0, 0);
        5:  exp_op = pk(C_SUB, 1, T1X, T1Z, 0, D1, D1, 0);
        6:  exp_op = pk(C_MUL, 0, S0, S0, 1, QS0, QS0, 0);
        7:  exp_op = pk(C_MUL, 0, D0, D0, 1, QD0, QD0, 0);
        8:  exp_op = pk(C_MUL, 0, S0, D1, 1, S0D1, S0D1, 0);
        9:  exp_op = pk(C_MUL, 0, S1, D0, 1, S1D0, S1D0, 0);
        10: exp_op = pk(C_ADD, 1, S1D0, S0D1, 0, TS, TS, 0);
        11: exp_op = pk(C_SUB, 1, S1D0, S0D1, 0, TD, TD, 0);
        12: exp_op = pk(C_MUL, 0, TD, TD, 1, QTD, QTD, 0);
        13: exp_op = pk(C_SUB, 1, QS0, QD0, 0, T0, T0, 0);
        14: exp_op = pk(C_MUL, 0, T0, A24, 1, TA, TA, 0);
        15: exp_op = pk(C_ADD, 1, TA, QD0, 0, T1, T1, 0);
        16: exp_op = pk(C_MUL, 1, QS0, QD0, 0, R0X, R0X, 0);
        17: exp_op = pk(C_MUL, 0, T0, T1, 1, R0Z, R0Z, 0);
        18: exp_op = pk(C_MUL, 0, TS, TS, 1, R1X, R1X, 0);
        19: exp_op = pk(C_MUL, 1, PX, QTD, 0, R1Z, R1Z, 0);
        default: exp_op = pk(C_MOVE, 1, R0Z, R1X, 0, R0Z, R1X, 0);
      endcase
    end else begin
      case (n - 3 - STEPS * 21)
        0: exp_op = pk(C_MOVE, 1, R0Z, R0Z, 0, IVI, IVI, 0);
        1: exp_op = pk(C_INV, 0, IVI, IVI, 1, IVO, IVO, 0);
        2: exp_op = pk(C_MOVE, 1, IVO, IVO, 0, IVO, IVO, 0);
        3: exp_op = pk(C_MUL, 0, IVO, R0X, 1, IVT, IVT, 0);
        4: exp_op = pk(C_ADD, 1, IVT, Z0, 0, IVO, IVO, 1);
        default: exp_op = pk(C_STORE, 0, IVO, IVO, 0, 0, 0, 0);
      endcase
    end
  endfunction

  function automatic int op_class(input int n);
    int j;
    if (n < 3) return 0;
    if (n >= 3 + STEPS * 21) return 4;
    j = (n - 3) % 21;
    if (j < 2) return 1;
    if (j == 20) return 3;
    return 2;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [255:0] k, input int lat, input int start_mid,
                     input int k_mid, input string tag);
    int n;
    int hold_err;
    int bank_err;
    int done_seen;
    int cls_err [5];
    logic [25:0] cls_act [5];
    logic [25:0] cls_exp [5];
    logic [25:0] cur;
    logic [25:0] want;
    string cls_name [5];
    cls_name[0] = "R4 init sequence";
    cls_name[1] = "R6 swap moves (bit order R5)";
    cls_name[2] = "R7 step arithmetic";
    cls_name[3] = "R8 closing move";
    cls_name[4] = "R9 tail sequence";
    for (int c = 0; c < 5; c++) begin
      cls_err[c] = 0; cls_act[c] = '0; cls_exp[c] = '0;
    end
    n = 0; hold_err = 0; bank_err = 0; done_seen = 0;

    @(negedge clk_i);
    scalar_i = k;
    start_i  = 1'b1;
    @(negedge clk_i);
    start_i  = 1'b0;
    chk(busy_o && op_valid_o, {"R1 busy after start ", tag}, {62'd0, busy_o, op_valid_o}, 64'd3);
    if (k_mid != 0) scalar_i = ~k;

    while (done_seen == 0 && !timed_out) begin
      if (done_o) begin
        done_seen = 1;
      end else if (op_valid_o) begin
        cur = dut_op();
        if (start_mid != 0 && n == 100) start_i = 1'b1;
        for (int w = 0; w < lat; w++) begin
          @(negedge clk_i);
          start_i = 1'b0;
          if (!op_valid_o || dut_op() != cur) hold_err++;
        end
        want = exp_op(k, n);
        if (cur != want) begin
          if (cls_err[op_class(n)] == 0) begin
            cls_act[op_class(n)] = cur;
            cls_exp[op_class(n)] = want;
          end
          cls_err[op_class(n)]++;
        end
        if ((cur[25:23] == 3'(C_ADD) || cur[25:23] == 3'(C_SUB) || cur[25:23] == 3'(C_MUL))
            && cur[22] == cur[11]) bank_err++;
        op_done_i = 1'b1;
        @(negedge clk_i);
        op_done_i = 1'b0;
        n++;
      end else begin
        @(negedge clk_i);
      end
    end

    for (int c = 0; c < 5; c++)
      chk(cls_err[c] == 0, {cls_name[c], " ", tag}, 64'(cls_act[c]), 64'(cls_exp[c]));
    chk(hold_err == 0, {"R3 fields held until op_done ", tag}, 64'(hold_err), 64'd0);
    chk(bank_err == 0, {"R12 arithmetic bank alternation ", tag}, 64'(bank_err), 64'd0);
    chk(n == TOTAL_OPS, {"R10 op count ", tag}, 64'(n), 64'(TOTAL_OPS));
    chk(done_seen == 1 && !busy_o, {"R1 done with busy low ", tag},
        {62'd0, 1'(done_seen), busy_o}, 64'd2);
    @(negedge clk_i);
    chk(!done_o && !op_valid_o, {"R1 done single cycle ", tag}, {62'd0, done_o, op_valid_o}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !op_valid_o, "R1 reset state",
        {61'd0, busy_o, done_o, op_valid_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !op_valid_o, "R1 idle after reset release", {62'd0, busy_o, op_valid_o}, 64'd0);

    for (int v = 0; v < NVEC; v++) begin
      if (!timed_out)
        run(VEC_K[v], VEC_LAT[v], VEC_SMID[v], VEC_KMID[v], $sformatf("vec%0d", v));
    end

    // stray op_done while idle is ignored (R3)
    @(negedge clk_i);
    op_done_i = 1'b1;
    @(negedge clk_i);
    op_done_i = 1'b0;
    @(negedge clk_i);
    chk(!busy_o && !op_valid_o && !done_o, "R3 idle op_done ignored",
        {61'd0, busy_o, op_valid_o, done_o}, 64'd0);
    // first op of the next run is the point load with encoding per R2
    @(negedge clk_i);
    scalar_i = 256'h8;
    start_i  = 1'b1;
    @(negedge clk_i);
    start_i  = 1'b0;
    chk(dut_op() == pk(C_LOAD, 0, 0, 0, 1, PX, PX, 0), "R2 load encoding",
        64'(dut_op()), 64'(pk(C_LOAD, 0, 0, 0, 1, PX, PX, 0)));
    // drain this run at zero latency; single set bit at position 3
    if (!timed_out) begin
      rst_ni = 1'b0;
      @(negedge clk_i);
      rst_ni = 1'b1;
      chk(!busy_o && !op_valid_o, "R1 reset aborts run", {62'd0, busy_o, op_valid_o}, 64'd0);
      run(256'h8, 0, 0, 0, "lowbit");
    end

    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired actual=%0d expected<%0d", cyc, WD_LIMIT);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule